// File: doc/BRIEF.md
# Accumulator Move and Return Unit

This block is the execute slice for one group of instructions in a small 8-bit accumulator machine. It takes an operation that has already been decoded, carries it out against its own state and reports the result on its outputs. That state is an accumulator, a 64-entry file of 8-bit registers, an option register, a zero flag, an interrupt-enable bit, a program counter and a short return-address stack. The operations are: store the accumulator into a register, load a constant into the accumulator, move a register to a chosen destination, do nothing, load the option register, and return from an interrupt.

An operation is offered with `op_valid` and is taken on any rising clock edge where `ready` is high. Every operation finishes in that edge except the return. The return holds `ready` low for one cycle and completes at the following edge. Return addresses enter the stack through a push port. The interrupt entry logic that sits outside this block drives that port. Arithmetic, instruction fetch and binary decoding are not part of this block.

Top module: `amr_exec`

## Requirements
- R1: Code 1 (store) writes the accumulator into file register `reg_addr` in the accepting edge. It leaves the accumulator, the zero flag and the option register unchanged.
- R2: Code 2 (constant load) places `imm` in the accumulator and leaves the zero flag unchanged.
- R3: Code 3 (register move) reads register `reg_addr`. With `dest_sel`=0 it writes the value to the accumulator. With `dest_sel`=1 it writes the value back to the same register and leaves the accumulator unchanged.
- R4: Code 3 sets `zero_flag` when the moved byte is 0x00 and clears it otherwise. No other code changes the zero flag.
- R5: Code 0 (no-op) and the unused codes 6 and 7 change nothing except the program counter.
- R6: Code 4 copies the accumulator into the option register.
- R7: Every accepted operation except code 5 adds one to `pc`, wrapping modulo 2^PC_W.
- R8: Code 5 (return) drives `ready` low for exactly the cycle after its acceptance, and no operation is accepted in that cycle. At the next edge it loads `pc` from the top of the stack, pops the stack and sets `gie`.
- R9: A push stores `push_addr` on the stack in last-in, first-out order. A push does not change `pc` and is ignored while `ready` is low.
- R10: A pop from an empty stack wraps the stack pointer to its highest slot and sets `stk_underflow`, which stays high until reset.
- R11: Reset takes effect asynchronously. It clears the accumulator, option register, zero flag, `gie`, `pc`, the stack pointer and `stk_underflow`. After reset `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_valid | input | 1 | An operation is offered |
| op_code | input | 3 | Pre-decoded operation: 0 no-op, 1 store, 2 constant load, 3 move, 4 option load, 5 return |
| reg_addr | input | 6 | File register address |
| imm | input | 8 | Constant for code 2 |
| dest_sel | input | 1 | Destination for code 3: 0 accumulator, 1 register |
| push_valid | input | 1 | Push `push_addr` onto the return stack |
| push_addr | input | PC_W (10) | Return address to push |
| ready | output | 1 | An operation can be accepted this cycle |
| acc | output | 8 | Accumulator |
| option | output | 8 | Option register |
| zero_flag | output | 1 | Zero flag |
| gie | output | 1 | Global interrupt enable |
| pc | output | PC_W (10) | Program counter |
| stk_underflow | output | 1 | Sticky flag: a pop was made from an empty stack |

## Verification
The hardest situation to reach is a return that pops an already empty stack and then loads an address from a slot that was only filled after the pointer wrapped. To build it, the stimulus pushes two addresses and returns through both. While the first return is busy, it also offers a push and a constant load, and checks that the block refuses both. A third return then underflows. A push after that lands in the wrapped slot at the top address. A return to that address followed by a no-op shows the program counter rolling over to zero.

// File: rtl/amr_pkg.sv
package amr_pkg;
  localparam int unsigned DATA_W = 8;

  localparam logic [2:0] OPC_NOP   = 3'd0;
  localparam logic [2:0] OPC_STORE = 3'd1;
  localparam logic [2:0] OPC_LDI   = 3'd2;
  localparam logic [2:0] OPC_MOVE  = 3'd3;
  localparam logic [2:0] OPC_OPTLD = 3'd4;
  localparam logic [2:0] OPC_RET   = 3'd5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RET  = 1'b1
  } amr_state_e;
endpackage

// File: rtl/amr_rstsync.sv
module amr_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/amr_ctrl.sv
module amr_ctrl
  import amr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [2:0] op_code,
  output logic       ready,
  output logic       do_store,
  output logic       do_ldi,
  output logic       do_move,
  output logic       do_optld,
  output logic       do_adv,
  output logic       do_pop
);
  amr_state_e state_q, state_d;
  logic       accept;

  assign ready  = (state_q == ST_IDLE);
  assign accept = op_valid & ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept && op_code == OPC_RET) state_d = ST_RET;
      ST_RET:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    do_store = accept && (op_code == OPC_STORE);
    do_ldi   = accept && (op_code == OPC_LDI);
    do_move  = accept && (op_code == OPC_MOVE);
    do_optld = accept && (op_code == OPC_OPTLD);
    do_adv   = accept && (op_code != OPC_RET);
    do_pop   = (state_q == ST_RET);
  end

  // R8: busy lasts a single cycle
  p_busy_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);
  // R8: an accepted return always makes the next cycle busy
  p_ret_goes_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ready && op_code == OPC_RET) |=> !ready);
endmodule

// File: rtl/amr_regfile.sv
module amr_regfile #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned ENTRIES = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];

  // R1: a write is visible at the written address one cycle later
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/amr_retstack.sv
module amr_retstack #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] top_data,
  output logic              underflow
);
  localparam int unsigned SP_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LVL_W = SP_W + 1;
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [SP_W-1:0]   sp_q, sp_d, top_idx;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              uf_q, uf_d;
  logic              wr_en;

  assign top_idx  = sp_q - 1'b1;
  assign top_data = slot_q[top_idx];
  assign wr_en    = push & ~pop;

  always_comb begin
    sp_d  = sp_q;
    lvl_d = lvl_q;
    uf_d  = uf_q;
    if (pop) begin
      sp_d = top_idx;
      if (lvl_q == '0) uf_d  = 1'b1;
      else             lvl_d = lvl_q - 1'b1;
    end else if (push) begin
      sp_d = sp_q + 1'b1;
      if (lvl_q != LVL_FULL) lvl_d = lvl_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      lvl_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      lvl_q <= lvl_d;
      uf_q  <= uf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[sp_q] <= push_data;
  end

  assign underflow = uf_q;

  // R10: underflow is sticky
  p_uflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R10: popping an empty stack raises underflow
  p_uflow_on_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && lvl_q == '0) |=> underflow);
  // R9: level never exceeds the depth
  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_FULL);
endmodule

// File: rtl/amr_exec.sv
module amr_exec
  import amr_pkg::*;
#(
  parameter int unsigned PC_W      = 10,
  parameter int unsigned RF_ADDR_W = 6,
  parameter int unsigned STK_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic [RF_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    imm,
  input  logic                 dest_sel,
  input  logic                 push_valid,
  input  logic [PC_W-1:0]      push_addr,
  output logic                 ready,
  output logic [DATA_W-1:0]    acc,
  output logic [DATA_W-1:0]    option,
  output logic                 zero_flag,
  output logic                 gie,
  output logic [PC_W-1:0]      pc,
  output logic                 stk_underflow
);
  logic rst_n_s;
  logic do_store, do_ldi, do_move, do_optld, do_adv, do_pop;
  logic rf_we;
  logic [DATA_W-1:0] rf_wdata, rf_rdata;
  logic [PC_W-1:0]   stk_top;
  logic              stk_push;

  logic [DATA_W-1:0] acc_q, acc_d, opt_q, opt_d;
  logic              z_q, z_d, gie_q, gie_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic              acc_en, opt_en, z_en, gie_en, pc_en;

  amr_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  amr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .op_valid(op_valid), .op_code(op_code),
    .ready(ready), .do_store(do_store), .do_ldi(do_ldi), .do_move(do_move),
    .do_optld(do_optld), .do_adv(do_adv), .do_pop(do_pop)
  );

  assign rf_we    = do_store | (do_move & dest_sel);
  assign rf_wdata = do_store ? acc_q : rf_rdata;

  amr_regfile #(.ADDR_W(RF_ADDR_W), .WORD_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n_s), .we(rf_we), .addr(reg_addr),
    .wdata(rf_wdata), .rdata(rf_rdata)
  );

  assign stk_push = push_valid & ready;

  amr_retstack #(.DEPTH(STK_DEPTH), .ADDR_W(PC_W)) u_stk (
    .clk(clk), .rst_n(rst_n_s), .push(stk_push), .push_data(push_addr),
    .pop(do_pop), .top_data(stk_top), .underflow(stk_underflow)
  );

  // next-state logic with explicit enables
  always_comb begin
    acc_en = do_ldi | (do_move & ~dest_sel);
    acc_d  = do_ldi ? imm : rf_rdata;
    opt_en = do_optld;
    opt_d  = acc_q;
    z_en   = do_move;
    z_d    = (rf_rdata == '0);
    gie_en = do_pop;
    gie_d  = 1'b1;
    pc_en  = do_adv | do_pop;
    pc_d   = do_pop ? stk_top : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc_q <= '0;
      opt_q <= '0;
      z_q   <= 1'b0;
      gie_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (opt_en) opt_q <= opt_d;
      if (z_en)   z_q   <= z_d;
      if (gie_en) gie_q <= gie_d;
      if (pc_en)  pc_q  <= pc_d;
    end
  end

  assign acc       = acc_q;
  assign option    = opt_q;
  assign zero_flag = z_q;
  assign gie       = gie_q;
  assign pc        = pc_q;

  // R7: accepted non-return operations step the program counter
  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && ready && op_code != OPC_RET) |=> (pc == $past(pc) + 1'b1));
  // R2: constant load lands in the accumulator
  p_ldi_value_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && ready && op_code == OPC_LDI) |=> (acc == $past(imm)));
  // R4: only a register move may change the zero flag
  p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(op_valid && ready && op_code == OPC_MOVE) |=> $stable(zero_flag));
  // R6: option load copies the accumulator
  p_opt_copy_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && ready && op_code == OPC_OPTLD) |=> (option == $past(acc)));
  // R8: interrupts are enabled when the return completes
  p_gie_on_return_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ready |=> gie);
  // R8: program counter is frozen while busy is being entered
  p_pc_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && ready && op_code == OPC_RET) |=> $stable(pc));
endmodule

// File: tb/amr_exec_tb.sv
module amr_exec_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_code;
  logic [5:0] reg_addr;
  logic [7:0] imm;
  logic       dest_sel;
  logic       push_valid;
  logic [9:0] push_addr;
  logic       ready;
  logic [7:0] acc, option;
  logic       zero_flag, gie, stk_underflow;
  logic [9:0] pc;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  amr_exec u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .reg_addr(reg_addr), .imm(imm), .dest_sel(dest_sel),
    .push_valid(push_valid), .push_addr(push_addr), .ready(ready),
    .acc(acc), .option(option), .zero_flag(zero_flag), .gie(gie),
    .pc(pc), .stk_underflow(stk_underflow)
  );

  // {op, addr, imm, dest, exp_acc, exp_zero, exp_opt}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {3'd2, 6'd0,  8'h5A, 1'b0, 8'h5A, 1'b0, 8'h00}, // R2 load 5A
    {3'd1, 6'd3,  8'h00, 1'b0, 8'h5A, 1'b0, 8'h00}, // R1 r3 <= 5A
    {3'd2, 6'd0,  8'h00, 1'b0, 8'h00, 1'b0, 8'h00}, // R2 load 00
    {3'd1, 6'd63, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00}, // R1 r63 <= 00
    {3'd3, 6'd3,  8'h00, 1'b0, 8'h5A, 1'b0, 8'h00}, // R3 r3 -> acc
    {3'd4, 6'd0,  8'h00, 1'b0, 8'h5A, 1'b0, 8'h5A}, // R6 option
    {3'd3, 6'd63, 8'h00, 1'b1, 8'h5A, 1'b1, 8'h5A}, // R4 test r63
    {3'd2, 6'd0,  8'hFF, 1'b0, 8'hFF, 1'b1, 8'h5A}, // R2 zero kept
    {3'd0, 6'd9,  8'h11, 1'b1, 8'hFF, 1'b1, 8'h5A}, // R5 no-op
    {3'd3, 6'd3,  8'h00, 1'b1, 8'hFF, 1'b0, 8'h5A}, // R4 test r3
    {3'd3, 6'd63, 8'h00, 1'b0, 8'h00, 1'b1, 8'h5A}, // R3 r63 -> acc
    {3'd7, 6'd3,  8'h22, 1'b1, 8'h00, 1'b1, 8'h5A}, // R5 unused code
    {3'd3, 6'd3,  8'h00, 1'b0, 8'h5A, 1'b0, 8'h5A}  // R3 r3 intact
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [5:0] a,
                       input logic [7:0] k, input logic d);
    op_valid = 1'b1; op_code = c; reg_addr = a; imm = k; dest_sel = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; reg_addr = '0; imm = '0;
    dest_sel = 1'b0; push_valid = 1'b0; push_addr = '0;
    repeat (3) @(negedge clk);
    chk("R11 acc in reset", acc, 0);
    chk("R11 pc in reset", pc, 0);
    chk("R11 gie in reset", gie, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 ready after reset", ready, 1);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][34:32], VEC[i][31:26], VEC[i][25:18], VEC[i][17]);
      @(negedge clk);
      chk($sformatf("vec%0d acc R1 R2 R3 R5", i), acc, VEC[i][16:9]);
      chk($sformatf("vec%0d zero R4", i), zero_flag, VEC[i][8]);
      chk($sformatf("vec%0d option R6", i), option, VEC[i][7:0]);
      chk($sformatf("vec%0d pc R7", i), pc, i + 1);
    end
    op_valid = 1'b0;

    // R9 pushes
    push_valid = 1'b1; push_addr = 10'h123;
    @(negedge clk);
    push_addr = 10'h045;
    @(negedge clk);
    push_valid = 1'b0;
    chk("R9 push leaves pc", pc, 13);

    // R8 first return, with traffic offered while busy
    issue(3'd5, 6'd0, 8'h00, 1'b0);
    @(negedge clk);
    chk("R8 ready low", ready, 0);
    chk("R8 pc held while busy", pc, 13);
    chk("R8 gie still low", gie, 0);
    issue(3'd2, 6'd0, 8'h77, 1'b0);
    push_valid = 1'b1; push_addr = 10'h3FF;
    @(negedge clk);
    push_valid = 1'b0;
    chk("R8 pc from stack", pc, 10'h045);
    chk("R8 gie set", gie, 1);
    chk("R8 ready back", ready, 1);
    chk("R8 load refused while busy", acc, 8'h5A);
    @(negedge clk);
    chk("R2 load after return", acc, 8'h77);
    chk("R7 pc after return", pc, 10'h046);

    issue(3'd5, 6'd0, 8'h00, 1'b0);
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    chk("R9 LIFO and busy push ignored", pc, 10'h123);
    chk("R10 no underflow yet", stk_underflow, 0);

    issue(3'd5, 6'd0, 8'h00, 1'b0);
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    chk("R10 underflow raised", stk_underflow, 1);
    chk("R10 ready after empty pop", ready, 1);

    // wrapped pointer: next push lands in the top slot
    push_valid = 1'b1; push_addr = 10'h3FF;
    @(negedge clk);
    push_valid = 1'b0;
    issue(3'd5, 6'd0, 8'h00, 1'b0);
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    chk("R10 wrapped slot popped", pc, 10'h3FF);
    chk("R10 underflow sticky", stk_underflow, 1);
    issue(3'd0, 6'd0, 8'h00, 1'b0);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R7 pc wraps to zero", pc, 0);

    // R11 asynchronous reset in mid run
    #1 rst_n = 1'b0;
    #1;
    chk("R11 acc cleared", acc, 0);
    chk("R11 option cleared", option, 0);
    chk("R11 gie cleared", gie, 0);
    chk("R11 underflow cleared", stk_underflow, 0);
    chk("R11 zero cleared", zero_flag, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 pc cleared", pc, 0);
    chk("R11 ready high", ready, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule